// File: doc/BRIEF.md
# Packet ECC Error Report Aggregator

This block sits behind a page-level ECC decoder. It gathers the decoder's per-packet results and reduces them to one 16-bit page error report and one page-empty flag. The decoder decodes a flash page one packet at a time and presents one result per packet. Each result carries the packet index, the number of corrected bits, a decode-success flag and an indication that the packet was fully erased.

Packet 0 is kept apart in the low byte of the report. Every other packet is folded into the high byte. That byte holds the worst corrected-bit count seen among them and a success bit that survives only if all of them decoded. A start pulse opens a page and resets the report. An end pulse closes the page and holds the report steady, so a host can read it at leisure. A page counts as empty only when every packet of the page reported erased. When the page is empty, the host ignores the counts.

Top module: `ecc_page_report`

## Requirements
- R1: After reset the report reads 0x8080 (both success bits set, both counts zero), `page_empty` is 1 and `report_ready` is 0.
- R2: A `page_start` pulse makes the report 0x8080, `page_empty` 1 and `report_ready` 0 from the following cycle on, whatever the previous page left behind.
- R3: Bits 5:0 hold the corrected-bit count of the most recent accepted packet with index 0. The count saturates at 63 when the input exceeds 63. Results appear one clock after the packet is accepted.
- R4: Bits 13:8 hold the maximum, not the sum, of the saturated counts of all accepted packets with index 1 or higher. The field is 0 if there are none.
- R5: Bit 7 is 1 when packet 0 decoded successfully and 0 when it failed.
- R6: Bit 15 is 1 only if every accepted packet with index 1 or higher decoded successfully. One failure clears it until the next `page_start`.
- R7: Bits 6 and 14 of the report are always 0.
- R8: `page_empty` is 1 only if every packet accepted since the last `page_start` had `pkt_erased` set.
- R9: A `page_end` pulse during a page sets `report_ready` one cycle later. From then on, the report and `page_empty` ignore packets and further `page_end` pulses until the next `page_start`.
- R10: Packets presented after reset and before the first `page_start` are ignored.
- R11: A packet presented in the same cycle as `page_start` is dropped. A packet presented in the same cycle as `page_end` is still included in the report.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| page_start | input | 1 | Pulse: open a new page and clear the report |
| page_end | input | 1 | Pulse: close the page and hold the report |
| pkt_valid | input | 1 | A packet result is presented this cycle |
| pkt_idx | input | IDX_W | Packet index within the page |
| pkt_errs | input | ERR_IN_W | Corrected-bit count from the decoder |
| pkt_ok | input | 1 | 1 = packet decoded successfully |
| pkt_erased | input | 1 | 1 = packet was entirely erased |
| err_report | output | 16 | Page error report |
| page_empty | output | 1 | All packets of the page were erased |
| report_ready | output | 1 | Page closed, report held |

## Verification
The bench builds the block with `ERR_IN_W` = 7 and `IDX_W` = 2. With a 7-bit count input, every count value from 0 to 127 can be swept on packet 0 with both success values, including everything on both sides of the saturation point at 63. With four packets per page, every one of the 16 erased/non-erased combinations can be tried for the empty flag. Pages of three later packets, with counts arranged so that the maximum lands on different positions and with the success bits cycled through all eight patterns, cover the max-reduction and the success AND.

// File: rtl/ecc_rpt_pkg.sv
// Shared constants and types for the page error report aggregator.
// Assumes the report layout is fixed at two 6-bit counts and two success bits.
package ecc_rpt_pkg;
    localparam int CNT_W = 6;
    localparam logic [CNT_W-1:0] CNT_MAX = '1;
    localparam logic [15:0] REPORT_CLEAR = 16'h8080;

    typedef enum logic [1:0] {
        PH_IDLE    = 2'd0,
        PH_COLLECT = 2'd1,
        PH_HELD    = 2'd2
    } phase_t;

    typedef struct packed {
        logic             ok;
        logic [CNT_W-1:0] cnt;
    } lane_t;
endpackage

// File: rtl/ecc_rpt_sat.sv
// Clamps a decoder corrected-bit count to the 6-bit report field.
// Assumes an unsigned count; narrow inputs are zero-extended.
module ecc_rpt_sat
    import ecc_rpt_pkg::*;
#(
    parameter int IN_W = 8
) (
    input  logic [IN_W-1:0]  raw,
    output logic [CNT_W-1:0] sat
);
    generate
        if (IN_W <= CNT_W) begin : g_narrow
            // fits without clamping
            assign sat = CNT_W'(raw);
        end else begin : g_wide
            // clamp anything above the field maximum
            always_comb sat = (raw > IN_W'(CNT_MAX)) ? CNT_MAX : raw[CNT_W-1:0];
        end
    endgenerate
endmodule

// File: rtl/ecc_rpt_lane.sv
// One half of the report: a count and a success bit.
// KEEP_MAX=0 overwrites with each update (first-packet lane).
// KEEP_MAX=1 keeps the running maximum count and ANDs success (later-packet lane).
// Assumes clr and upd are never asserted together (the control drops the packet).
module ecc_rpt_lane
    import ecc_rpt_pkg::*;
#(
    parameter bit KEEP_MAX = 1'b0
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  clr,
    input  logic  upd,
    input  lane_t din,
    output lane_t q
);
    // hold or fold the lane value
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            q <= '{ok: 1'b1, cnt: '0};
        end else if (upd) begin
            if (KEEP_MAX) begin
                q.cnt <= (din.cnt > q.cnt) ? din.cnt : q.cnt;
                q.ok  <= q.ok & din.ok;
            end else begin
                q <= din;
            end
        end
    end

    generate
        if (KEEP_MAX) begin : g_chk_max
            p_max_monotone_r4: assert property (@(posedge clk) disable iff (!rst_n)
                !clr |=> q.cnt >= $past(q.cnt));
            p_ok_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
                (!clr && !q.ok) |=> !q.ok);
        end
    endgenerate
endmodule

// File: rtl/ecc_rpt_ctrl.sv
// Page phase tracking: idle until the first start, collecting within a page,
// held after the end pulse. Produces the clear and packet-accept strobes.
// Assumes start and end are single-cycle pulses; start takes priority.
module ecc_rpt_ctrl
    import ecc_rpt_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic page_start,
    input  logic page_end,
    input  logic pkt_valid,
    output logic clr,
    output logic accept,
    output logic held
);
    phase_t phase;

    // advance the page phase
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= PH_IDLE;
        end else if (page_start) begin
            phase <= PH_COLLECT;
        end else if (page_end && phase == PH_COLLECT) begin
            phase <= PH_HELD;
        end
    end

    // strobes for the datapath
    always_comb begin
        clr    = page_start;
        accept = pkt_valid && !page_start && (phase == PH_COLLECT);
        held   = (phase == PH_HELD);
    end

    p_held_until_start_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_HELD && !page_start) |=> phase == PH_HELD);
    p_idle_until_start_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_IDLE && !page_start) |=> phase == PH_IDLE);
endmodule

// File: rtl/ecc_page_report.sv
// Page error report aggregator. Routes packet 0 to the first lane and all
// other packets to the worst-case lane, tracks whether every packet was erased,
// and packs the 16-bit report. Assumes one packet result per cycle at most.
module ecc_page_report
    import ecc_rpt_pkg::*;
#(
    parameter int ERR_IN_W = 8,
    parameter int IDX_W    = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                page_start,
    input  logic                page_end,
    input  logic                pkt_valid,
    input  logic [IDX_W-1:0]    pkt_idx,
    input  logic [ERR_IN_W-1:0] pkt_errs,
    input  logic                pkt_ok,
    input  logic                pkt_erased,
    output logic [15:0]         err_report,
    output logic                page_empty,
    output logic                report_ready
);
    localparam int N_LANES = 2;

    logic               clr, accept, held;
    logic [CNT_W-1:0]   cnt_sat;
    lane_t              din;
    lane_t              lane_q [N_LANES];
    logic [N_LANES-1:0] lane_upd;
    logic               is_first;

    ecc_rpt_ctrl u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .page_start (page_start),
        .page_end   (page_end),
        .pkt_valid  (pkt_valid),
        .clr        (clr),
        .accept     (accept),
        .held       (held)
    );

    ecc_rpt_sat #(.IN_W(ERR_IN_W)) u_sat (
        .raw (pkt_errs),
        .sat (cnt_sat)
    );

    // route the accepted packet to its lane
    always_comb begin
        is_first    = (pkt_idx == '0);
        din         = '{ok: pkt_ok, cnt: cnt_sat};
        lane_upd[0] = accept && is_first;
        lane_upd[1] = accept && !is_first;
    end

    generate
        for (genvar g = 0; g < N_LANES; g++) begin : g_lane
            ecc_rpt_lane #(.KEEP_MAX(g != 0)) u_lane (
                .clk   (clk),
                .rst_n (rst_n),
                .clr   (clr),
                .upd   (lane_upd[g]),
                .din   (din),
                .q     (lane_q[g])
            );
        end
    endgenerate

    // empty flag survives only erased packets
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            page_empty <= 1'b1;
        end else if (accept && !pkt_erased) begin
            page_empty <= 1'b0;
        end
    end

    // pack the report
    always_comb begin
        err_report   = {lane_q[1].ok, 1'b0, lane_q[1].cnt,
                        lane_q[0].ok, 1'b0, lane_q[0].cnt};
        report_ready = held;
    end

    p_start_clears_r2: assert property (@(posedge clk) disable iff (!rst_n)
        page_start |=> (err_report == REPORT_CLEAR) && page_empty && !report_ready);
    p_first_count_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && is_first && pkt_errs < ERR_IN_W'(64 % (1 << ERR_IN_W)))
        |=> err_report[5:0] == $past(cnt_sat));
    p_first_ok_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && is_first) |=> err_report[7] == $past(pkt_ok));
    p_empty_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!page_empty && !page_start) |=> !page_empty);
    p_hold_stable_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (report_ready && !page_start) |=> $stable(err_report) && $stable(page_empty));
endmodule

// File: tb/sim_ecc_page_report.sv
module sim_ecc_page_report;
    localparam int EW = 7;
    localparam int IW = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          page_start = 1'b0, page_end = 1'b0, pkt_valid = 1'b0;
    logic [IW-1:0] pkt_idx = '0;
    logic [EW-1:0] pkt_errs = '0;
    logic          pkt_ok = 1'b0, pkt_erased = 1'b0;
    logic [15:0]   err_report;
    logic          page_empty, report_ready;

    int total = 0;
    int fails = 0;
    bit done  = 1'b0;

    always #4 clk = ~clk;

    ecc_page_report #(.ERR_IN_W(EW), .IDX_W(IW)) u0 (
        .clk(clk), .rst_n(rst_n), .page_start(page_start), .page_end(page_end),
        .pkt_valid(pkt_valid), .pkt_idx(pkt_idx), .pkt_errs(pkt_errs),
        .pkt_ok(pkt_ok), .pkt_erased(pkt_erased),
        .err_report(err_report), .page_empty(page_empty), .report_ready(report_ready)
    );

    function automatic int sat6(int x);
        return (x > 63) ? 63 : x;
    endfunction

    function automatic logic [15:0] word(bit ok0, int c0, bit okn, int cn);
        return {okn, 1'b0, 6'(cn), ok0, 1'b0, 6'(c0)};
    endfunction

    task automatic chk(string req, int act, int exp);
        total++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    // drive one cycle from a negedge; returns at the following negedge
    task automatic step(bit st, bit en, bit v, int idx, int cnt, bit ok, bit er);
        page_start = st; page_end = en; pkt_valid = v;
        pkt_idx = IW'(idx); pkt_errs = EW'(cnt); pkt_ok = ok; pkt_erased = er;
        @(posedge clk);
        @(negedge clk);
        page_start = 1'b0; page_end = 1'b0; pkt_valid = 1'b0;
    endtask

    task automatic pkt(int idx, int cnt, bit ok, bit er);
        step(1'b0, 1'b0, 1'b1, idx, cnt, ok, er);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++; fails++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 report", err_report, 16'h8080);
        chk("R1 empty", page_empty, 1);
        chk("R1 ready", report_ready, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R10 packets before the first start are ignored
        pkt(0, 5, 0, 0);
        pkt(2, 40, 0, 0);
        chk("R10 report", err_report, 16'h8080);
        chk("R10 empty", page_empty, 1);

        // R3 R5 R7 sweep of packet 0 count and success
        for (int c = 0; c < 128; c++) begin
            for (int k = 0; k < 2; k++) begin
                step(1'b1, 1'b0, 1'b0, 0, 0, 0, 0);
                pkt(0, c, k[0], 0);
                step(1'b0, 1'b1, 1'b0, 0, 0, 0, 0);
                chk("R3 R5 R7 first packet", err_report, word(k[0], sat6(c), 1'b1, 0));
                chk("R9 ready", report_ready, 1);
            end
        end

        // R4 R6 sweep of later packets: max and AND
        for (int a = 0; a < 128; a++) begin
            int c1 = a, c2 = 127 - a, c3 = (a * 37) % 128;
            int m = sat6(c1);
            if (sat6(c2) > m) m = sat6(c2);
            if (sat6(c3) > m) m = sat6(c3);
            step(1'b1, 1'b0, 1'b0, 0, 0, 0, 0);
            pkt(1, c1, a[0], 0);
            pkt(2, c2, a[1], 0);
            pkt(3, c3, a[2], 0);
            step(1'b0, 1'b1, 1'b0, 0, 0, 0, 0);
            chk("R4 R6 later packets", err_report,
                word(1'b1, 0, a[0] & a[1] & a[2], m));
        end

        // R8 every erased/non-erased mix over four packets
        for (int mask = 0; mask < 16; mask++) begin
            step(1'b1, 1'b0, 1'b0, 0, 0, 0, 0);
            for (int i = 0; i < 4; i++) pkt(i, i, 1, mask[i]);
            step(1'b0, 1'b1, 1'b0, 0, 0, 0, 0);
            chk("R8 empty", page_empty, (mask == 15) ? 1 : 0);
        end

        // R9 held report ignores packets and repeated end pulses
        step(1'b1, 1'b0, 1'b0, 0, 0, 0, 0);
        pkt(0, 12, 1, 1);
        pkt(1, 7, 1, 1);
        step(1'b0, 1'b1, 1'b0, 0, 0, 0, 0);
        pkt(0, 63, 0, 0);
        pkt(3, 50, 0, 0);
        step(1'b0, 1'b1, 1'b0, 0, 0, 0, 0);
        chk("R9 held report", err_report, word(1'b1, 12, 1'b1, 7));
        chk("R9 held empty", page_empty, 1);
        chk("R9 held ready", report_ready, 1);

        // R2 start after a dirty page clears everything
        step(1'b1, 1'b0, 1'b0, 0, 0, 0, 0);
        pkt(0, 30, 0, 0);
        pkt(2, 45, 0, 0);
        step(1'b0, 1'b1, 1'b0, 0, 0, 0, 0);
        step(1'b1, 1'b0, 1'b0, 0, 0, 0, 0);
        chk("R2 report", err_report, 16'h8080);
        chk("R2 empty", page_empty, 1);
        chk("R2 ready", report_ready, 0);

        // R11 packet with start is dropped
        step(1'b1, 1'b0, 1'b1, 0, 9, 0, 0);
        step(1'b0, 1'b1, 1'b0, 0, 0, 0, 0);
        chk("R11 start drop", err_report, 16'h8080);
        chk("R11 start drop empty", page_empty, 1);

        // R11 packet with end is included
        step(1'b1, 1'b0, 1'b0, 0, 0, 0, 0);
        step(1'b0, 1'b1, 1'b1, 1, 20, 1, 0);
        chk("R11 end keep", err_report, word(1'b1, 0, 1'b1, 20));
        chk("R11 end keep empty", page_empty, 0);

        // R3 repeated packet 0 within a page: last one wins
        step(1'b1, 1'b0, 1'b0, 0, 0, 0, 0);
        pkt(0, 40, 1, 0);
        pkt(0, 3, 0, 0);
        step(1'b0, 1'b1, 1'b0, 0, 0, 0, 0);
        chk("R3 last first-packet", err_report, word(1'b0, 3, 1'b1, 0));

        done = 1'b1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule